// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames with 16x oversampling and supports an address/data framing scheme for multi-drop links. Each frame has a start bit, eight data bits sent least significant bit first, an optional extra bit that marks the frame as an address (1) or a data frame (0), and a stop bit. Received bytes move from a shift register into a holding register, and status flags report a full holding register, a framing error, an overrun, and the marker bit of the last accepted frame. Two interrupt outputs follow these flags, each gated by its own enable.

A wake-up filter lets a node ignore traffic addressed to other nodes. Software arms it by writing 1 to the arm bit. While armed, with the marker-bit format on and the asynchronous mode selected, frames whose marker bit is 0 are thrown away completely: no transfer, no error detection, no flag and no interrupt. The first frame with marker bit 1 is accepted normally, its marker is recorded, and the filter disarms itself, so the frames that follow are received normally. The filter has no effect in clock-synchronous mode or with the marker-bit format off. The oversampling strobe comes from an external baud generator.

The sampler is a state machine with states IDLE, START, DATA, MARK and STOP. IDLE goes to START on a low receive line. START goes back to IDLE if the line is high at the start-bit midpoint (glitch) and otherwise goes to DATA. DATA goes to MARK after the last data bit when the marker format is on, and to STOP when it is off. MARK goes to STOP after one bit time. STOP samples the stop bit, reports the finished frame and returns to IDLE.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the holding register reads 0, every status flag and both interrupt outputs are 0, and the filter is disarmed.
- R2: A frame is sampled at the midpoint of each 16-tick bit time (tick counter value 7 for the start bit, 15 for the others); data bits arrive least significant first; when the frame has a good stop bit, the filter does not drop it and the holding register is empty, the byte is copied to the holding register and the full flag is set. The shift-register output holds the last byte shifted in.
- R3: A low pulse on the line that has ended before the start-bit midpoint is rejected, and a following frame is received correctly.
- R4: A stop bit sampled as 0 sets the framing-error flag and the byte is not copied to the holding register.
- R5: A good frame that finishes while the full flag is set sets the overrun flag and leaves the holding register unchanged.
- R6: While armed, in asynchronous mode with the marker format on, a frame with marker bit 0 changes neither the holding register nor the full, framing-error, overrun or marker flags, and raises no interrupt, even when its stop bit is bad or the holding register is full.
- R7: While the filter is on, a frame with marker bit 1 sets the marker flag, disarms the filter and is transferred; later frames with marker bit 0 are received normally and clear the marker flag.
- R8: In clock-synchronous mode, or with the marker format off, the arm bit is ignored: frames with any marker value are received normally and the arm bit keeps its value.
- R9: Software writing 0 to the arm bit disarms it on the next cycle; a software write wins over a hardware disarm in the same cycle.
- R10: The receive interrupt equals the full flag gated by its enable; the error interrupt equals the OR of the framing-error and overrun flags gated by its enable.
- R11: With the marker format off, a frame is 10 bits long (no marker bit) and the marker flag keeps its value.
- R12: The full-clear input clears the full flag, and the error-clear input clears the framing-error and overrun flags; a flag set by a frame in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | 16x oversampling strobe |
| rxd | input | 1 | Serial receive line, idle high |
| sync_mode | input | 1 | 1 selects clock-synchronous mode (filter inactive) |
| mp_fmt | input | 1 | 1 adds the marker bit to each frame |
| wake_we | input | 1 | Software write strobe for the arm bit |
| wake_wd | input | 1 | Value written to the arm bit |
| clr_full | input | 1 | Clear the full flag |
| clr_err | input | 1 | Clear framing-error and overrun flags |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| rx_shift | output | DATA_BITS | Receive shift register |
| rx_data | output | DATA_BITS | Receive holding register |
| rx_full | output | 1 | Holding register full |
| frame_err | output | 1 | Framing error flag |
| overrun | output | 1 | Overrun flag |
| mp_flag | output | 1 | Marker bit of the last accepted frame |
| wake_armed | output | 1 | Filter arm bit |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench builds the block with its defaults, eight data bits and 16 ticks per bit, and holds the oversampling strobe high so each bit lasts 16 clocks and a full frame with marker bit fits in 176 clocks. This puts every sampling midpoint, the glitch window shorter than half a bit, both frame lengths, and the interplay of the filter with a full holding register and a bad stop bit within a few thousand cycles of directed traffic.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_MARK,
        S_STOP
    } rx_state_e;
endpackage

// File: rtl/mp_rx_sampler.sv
module mp_rx_sampler
    import mp_uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 mp_fmt,
    output logic [DATA_BITS-1:0] shift_q,
    output logic                 frm_done,
    output logic                 frm_mpb,
    output logic                 frm_stop_ok
);
    localparam int CW  = $clog2(OVS);
    localparam int IW  = $clog2(DATA_BITS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [IW-1:0] TOP  = IW'(DATA_BITS - 1);

    rx_state_e     st, st_n;
    logic [1:0]    sync_q;
    logic          rx_s;
    logic [CW-1:0] cnt;
    logic [IW-1:0] bit_idx;
    logic          samp;

    assign rx_s = sync_q[1];
    assign samp = os_tick && (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // transitions
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:  if (!rx_s) st_n = S_START;
            S_START: if (os_tick && cnt == MID) st_n = rx_s ? S_IDLE : S_DATA;
            S_DATA:  if (samp && bit_idx == TOP) st_n = mp_fmt ? S_MARK : S_STOP;
            S_MARK:  if (samp) st_n = S_STOP;
            S_STOP:  if (samp) st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q      <= 2'b11;
            cnt         <= '0;
            bit_idx     <= '0;
            shift_q     <= '0;
            frm_done    <= 1'b0;
            frm_mpb     <= 1'b0;
            frm_stop_ok <= 1'b0;
        end else begin
            sync_q   <= {sync_q[0], rxd};
            frm_done <= 1'b0;
            if (st != st_n || st == S_IDLE) cnt <= '0;
            else if (os_tick)               cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            unique case (st)
                S_IDLE: begin
                    bit_idx <= '0;
                    frm_mpb <= 1'b0;
                end
                S_DATA: if (samp) begin
                    shift_q <= {rx_s, shift_q[DATA_BITS-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
                S_MARK: if (samp) frm_mpb <= rx_s;
                S_STOP: if (samp) begin
                    frm_done    <= 1'b1;
                    frm_stop_ok <= rx_s;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_done,
    input  logic [DATA_BITS-1:0] frm_data,
    input  logic                 frm_mpb,
    input  logic                 frm_stop_ok,
    input  logic                 sync_mode,
    input  logic                 mp_fmt,
    input  logic                 wake_we,
    input  logic                 wake_wd,
    input  logic                 clr_full,
    input  logic                 clr_err,
    output logic [DATA_BITS-1:0] rdr,
    output logic                 full,
    output logic                 ferr,
    output logic                 oerr,
    output logic                 mpb,
    output logic                 wake
);
    logic filt_on, drop;

    assign filt_on = wake && mp_fmt && !sync_mode;
    assign drop    = filt_on && !frm_mpb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdr  <= '0;
            full <= 1'b0;
            ferr <= 1'b0;
            oerr <= 1'b0;
            mpb  <= 1'b0;
            wake <= 1'b0;
        end else begin
            if (clr_full) full <= 1'b0;
            if (clr_err) begin
                ferr <= 1'b0;
                oerr <= 1'b0;
            end
            if (wake_we) wake <= wake_wd;
            if (frm_done && !drop) begin
                if (mp_fmt) mpb <= frm_mpb;
                if (filt_on && !wake_we) wake <= 1'b0;
                if (!frm_stop_ok) ferr <= 1'b1;
                else if (full)    oerr <= 1'b1;
                else begin
                    rdr  <= frm_data;
                    full <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 sync_mode,
    input  logic                 mp_fmt,
    input  logic                 wake_we,
    input  logic                 wake_wd,
    input  logic                 clr_full,
    input  logic                 clr_err,
    input  logic                 rx_ie,
    input  logic                 err_ie,
    output logic [DATA_BITS-1:0] rx_shift,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 frame_err,
    output logic                 overrun,
    output logic                 mp_flag,
    output logic                 wake_armed,
    output logic                 irq_rx,
    output logic                 irq_err
);
    logic frm_done, frm_mpb, frm_stop_ok;

    mp_rx_sampler #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_samp (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .mp_fmt(mp_fmt),
        .shift_q(rx_shift), .frm_done(frm_done), .frm_mpb(frm_mpb),
        .frm_stop_ok(frm_stop_ok)
    );

    mp_rx_filter #(.DATA_BITS(DATA_BITS)) u_filt (
        .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_data(rx_shift),
        .frm_mpb(frm_mpb), .frm_stop_ok(frm_stop_ok), .sync_mode(sync_mode),
        .mp_fmt(mp_fmt), .wake_we(wake_we), .wake_wd(wake_wd),
        .clr_full(clr_full), .clr_err(clr_err), .rdr(rx_data), .full(rx_full),
        .ferr(frame_err), .oerr(overrun), .mpb(mp_flag), .wake(wake_armed)
    );

    assign irq_rx  = rx_ie && rx_full;
    assign irq_err = err_ie && (frame_err || overrun);
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frm_done,
    input logic                 frm_mpb,
    input logic                 frm_stop_ok,
    input logic                 sync_mode,
    input logic                 mp_fmt,
    input logic                 wake_we,
    input logic                 clr_full,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_full,
    input logic                 frame_err,
    input logic                 overrun,
    input logic                 mp_flag,
    input logic                 wake_armed
);
    logic armed_on;
    assign armed_on = wake_armed && mp_fmt && !sync_mode;

    p_full_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(frm_done));

    p_overrun_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && frm_stop_ok && rx_full && !clr_full && !(armed_on && !frm_mpb)
        |=> overrun && $stable(rx_data));

    p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && armed_on && !frm_mpb
        |=> $stable(rx_data) && !$rose(rx_full) && !$rose(frame_err)
            && !$rose(overrun) && $stable(mp_flag));

    p_wake_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && armed_on && frm_mpb && !wake_we |=> !wake_armed && mp_flag);

    p_mode_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && (sync_mode || !mp_fmt) && !wake_we |=> $stable(wake_armed));
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_mpb(frm_mpb),
    .frm_stop_ok(frm_stop_ok), .sync_mode(sync_mode), .mp_fmt(mp_fmt),
    .wake_we(wake_we), .clr_full(clr_full), .rx_data(rx_data),
    .rx_full(rx_full), .frame_err(frame_err), .overrun(overrun),
    .mp_flag(mp_flag), .wake_armed(wake_armed)
);

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
    localparam int DW = 8;
    localparam int OV = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b1;
    logic rxd = 1'b1;
    logic sync_mode = 1'b0, mp_fmt = 1'b1;
    logic wake_we = 1'b0, wake_wd = 1'b0;
    logic clr_full = 1'b0, clr_err = 1'b0;
    logic rx_ie = 1'b0, err_ie = 1'b0;
    logic [DW-1:0] rx_shift, rx_data;
    logic rx_full, frame_err, overrun, mp_flag, wake_armed, irq_rx, irq_err;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    mp_uart_rx #(.DATA_BITS(DW), .OVS(OV)) dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .sync_mode(sync_mode), .mp_fmt(mp_fmt), .wake_we(wake_we),
        .wake_wd(wake_wd), .clr_full(clr_full), .clr_err(clr_err),
        .rx_ie(rx_ie), .err_ie(err_ie), .rx_shift(rx_shift), .rx_data(rx_data),
        .rx_full(rx_full), .frame_err(frame_err), .overrun(overrun),
        .mp_flag(mp_flag), .wake_armed(wake_armed), .irq_rx(irq_rx),
        .irq_err(irq_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_bit(input logic b);
        rxd = b;
        repeat (OV) @(negedge clk);
    endtask

    task automatic send(input logic [DW-1:0] d, input logic mk, input logic stp, input logic with_mk);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < DW; i++) hold_bit(d[i]);
        if (with_mk) hold_bit(mk);
        hold_bit(stp);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_full = 1'b1; clr_err = 1'b1;
        @(negedge clk);
        clr_full = 1'b0; clr_err = 1'b0;
    endtask

    task automatic arm(input logic v);
        @(negedge clk);
        wake_we = 1'b1; wake_wd = v;
        @(negedge clk);
        wake_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rx_data", rx_data, 0);
        check("R1 flags", {rx_full, frame_err, overrun, mp_flag}, 0);
        check("R1 irqs", {irq_rx, irq_err}, 0);
        check("R1 wake_armed", wake_armed, 0);
    endtask

    task automatic t_normal();
        send(8'hC5, 1'b0, 1'b1, 1'b1);
        check("R2 rx_data", rx_data, 8'hC5);
        check("R2 rx_full", rx_full, 1);
        check("R2 rx_shift", rx_shift, 8'hC5);
        pulse_clear();
        check("R12 full cleared", rx_full, 0);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R3 glitch no frame", rx_full, 0);
        send(8'h3C, 1'b0, 1'b1, 1'b1);
        check("R3 frame after glitch", rx_data, 8'h3C);
        pulse_clear();
    endtask

    task automatic t_ferr();
        err_ie = 1'b1;
        send(8'h77, 1'b0, 1'b0, 1'b1);
        check("R4 frame_err", frame_err, 1);
        check("R4 no transfer", {rx_full, rx_data}, {1'b0, 8'h3C});
        check("R10 irq_err", irq_err, 1);
        pulse_clear();
        check("R12 err cleared", {frame_err, irq_err}, 0);
    endtask

    task automatic t_overrun();
        rx_ie = 1'b1;
        send(8'h11, 1'b0, 1'b1, 1'b1);
        check("R10 irq_rx", irq_rx, 1);
        send(8'h22, 1'b0, 1'b1, 1'b1);
        check("R5 overrun", overrun, 1);
        check("R5 data kept", rx_data, 8'h11);
        rx_ie = 1'b0;
        @(negedge clk);
        check("R10 irq_rx gated", irq_rx, 0);
        rx_ie = 1'b1;
        pulse_clear();
    endtask

    task automatic t_filter();
        send(8'h44, 1'b0, 1'b1, 1'b1);   // fill holding register
        arm(1'b1);
        check("R6 armed", wake_armed, 1);
        send(8'h55, 1'b0, 1'b1, 1'b1);   // would overrun if accepted
        check("R6 no overrun", {overrun, rx_data}, {1'b0, 8'h44});
        send(8'h66, 1'b0, 1'b0, 1'b1);   // bad stop, dropped
        check("R6 no frame_err", {frame_err, irq_err}, 0);
        pulse_clear();
        send(8'h33, 1'b0, 1'b1, 1'b1);
        check("R6 dropped data", {rx_full, irq_rx, rx_data, mp_flag}, {2'b00, 8'h44, 1'b0});
        check("R6 still armed", wake_armed, 1);
        send(8'hA5, 1'b1, 1'b1, 1'b1);
        check("R7 address accepted", {rx_full, rx_data}, {1'b1, 8'hA5});
        check("R7 mp_flag and disarm", {mp_flag, wake_armed}, 2'b10);
        pulse_clear();
        send(8'h5A, 1'b0, 1'b1, 1'b1);
        check("R7 later data", {rx_full, rx_data, mp_flag}, {1'b1, 8'h5A, 1'b0});
        pulse_clear();
    endtask

    task automatic t_bypass();
        arm(1'b1);
        sync_mode = 1'b1;
        send(8'h81, 1'b0, 1'b1, 1'b1);
        check("R8 sync mode receives", {rx_full, rx_data}, {1'b1, 8'h81});
        check("R8 arm kept", wake_armed, 1);
        pulse_clear();
        sync_mode = 1'b0;
        send(8'h90, 1'b1, 1'b1, 1'b1);   // sets marker flag, disarms
        pulse_clear();
        arm(1'b1);
        mp_fmt = 1'b0;
        send(8'h92, 1'b0, 1'b1, 1'b0);   // 10-bit frame
        check("R11 short frame", {rx_full, rx_data, frame_err}, {1'b1, 8'h92, 1'b0});
        check("R11 mp_flag kept", mp_flag, 1);
        check("R8 arm kept fmt off", wake_armed, 1);
        mp_fmt = 1'b1;
        pulse_clear();
    endtask

    task automatic t_sw_clear();
        arm(1'b0);
        check("R9 sw disarm", wake_armed, 0);
        send(8'h0F, 1'b0, 1'b1, 1'b1);
        check("R9 data after disarm", {rx_full, rx_data}, {1'b1, 8'h0F});
        pulse_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_glitch();
        t_ferr();
        t_overrun();
        t_filter();
        t_bypass();
        t_sw_clear();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule